// File: doc/BRIEF.md
# Serial EEPROM Target with Timed Write Cycle

This block answers as a byte-wide memory on a two-wire serial bus. It watches the clock and data lines on the system clock, finds start and stop conditions, and decodes the control byte. The upper seven bits of that byte select this target, and the lowest bit chooses between writing and reading. A write carries a word address followed by any number of data bytes. Each data byte lands in the array at once, and the shared pointer advances after it.

When a stop closes a write that carried at least one data byte, a programming interval begins. A cycle counter times it. Until the interval ends the target ignores its own address, so a host can poll with bare control bytes to learn when the write has finished. Reads use the same pointer. A read with no address returns the byte after the last one accessed. A write that carries only an address, followed by a repeated start and a read, gives a random read. If the host acknowledges each byte, the read continues byte after byte, and the pointer wraps at the top of the array. A protect input blocks all changes to the array while it is high.

Top module: `i2c_eeprom_target`

## Requirements
- R1: A stop after a write with one or more data bytes starts a busy interval of WRITE_CYCLES clocks. A write that carried only a word address starts no interval.
- R2: While busy, the target leaves SDA released in the ninth clock of its control byte (no acknowledge), whatever the R/W bit is. Once the interval has ended, the same control byte is acknowledged.
- R3: While wp_i is 1, data bytes are still acknowledged, but the array keeps its contents and no busy interval follows the stop.
- R4: Control byte bits [7:1] must equal DEV_ADDR, or the target does not acknowledge and stays silent until the next start. Bit 0 equal to 1 selects a read and 0 selects a write.
- R5: The pointer holds the last accessed address plus one. A read that sends no address, made after an access to n, returns the byte at n+1.
- R6: For a read, the target acknowledges the control byte and then shifts out 8 data bits, most significant bit first.
- R7: After a data byte that the host does not acknowledge, followed by a stop, SDA stays released.
- R8: The word address of a write is loaded into the pointer at its acknowledge, even when a repeated start follows at once. A following read starts at that address.
- R9: When the host acknowledges a read byte, the next byte follows. The pointer wraps from 2^ADDR_W-1 to 0, for both reads and writes.
- R10: The target changes its SDA drive only while SCL is low. It drives acknowledges in the ninth clock, and SDA is released after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low (open drain); 0 releases it |
| wp_i | input | 1 | Write protect; 1 blocks all array changes |

## Verification
Two events can meet in one cycle: the end of the busy interval and the acknowledge decision for a control byte that arrives at that moment. The bench provokes this by polling back to back from the stop onward. It judges the result by requiring that the first poll is refused and that the first acknowledged poll comes no sooner than the programmed interval allows, and not long after it. The bench also drives a dummy write straight into a read and a poll. This checks that an address-only write never raises busy at the point where a real write would.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
   localparam int unsigned BYTE_W = 8;
   localparam int unsigned BITCNT_W = 4;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_CTRL,
      ST_CTRL_ACK,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_WDATA,
      ST_WDATA_ACK,
      ST_RDATA,
      ST_RACK
   } bus_state_e;
endpackage

// File: rtl/i2c_ee_line_sync.sv
module i2c_ee_line_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic level,
   output logic rise,
   output logic fall
);
   logic prev_q;

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("i2c_ee_line_sync: STAGES must be at least 1");
      end

      if (STAGES == 1) begin : g_single
         logic stage_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q <= RST_VAL;
            else        stage_q <= din;
         end
         assign level = stage_q;
      end else begin : g_chain
         logic [STAGES-1:0] stage_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q <= {STAGES{RST_VAL}};
            else        stage_q <= {stage_q[STAGES-2:0], din};
         end
         assign level = stage_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RST_VAL;
      else        prev_q <= level;
   end

   assign rise = level & ~prev_q;
   assign fall = ~level & prev_q;
endmodule

// File: rtl/i2c_ee_wr_timer.sv
module i2c_ee_wr_timer #(
   parameter int unsigned CYCLES = 5000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int unsigned CNT_W = $clog2(CYCLES + 1);

   logic [CNT_W-1:0] remain_q;

   generate
      if (CYCLES < 1) begin : g_bad_cycles
         $error("i2c_ee_wr_timer: CYCLES must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      remain_q <= '0;
      else if (start)                  remain_q <= CNT_W'(CYCLES);
      else if (remain_q != '0)         remain_q <= remain_q - CNT_W'(1);
   end

   assign busy = (remain_q != '0);

   AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy); // R1

   AST_IDLE_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> !busy); // R1
endmodule

// File: rtl/i2c_ee_array.sv
module i2c_ee_array #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];

   generate
      if (ADDR_W < 1 || ADDR_W > 11) begin : g_bad_depth
         $error("i2c_ee_array: ADDR_W out of range 1..11");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];
endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target #(
   parameter int unsigned ADDR_W       = 8,
   parameter logic [6:0]  DEV_ADDR     = 7'h50,
   parameter int unsigned WRITE_CYCLES = 5000,
   parameter int unsigned SYNC_STAGES  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_oe,
   input  logic wp_i
);
   import i2c_ee_pkg::*;

   localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(BYTE_W);
   localparam logic [ADDR_W-1:0]   PTR_ONE  = ADDR_W'(1);

   generate
      if (ADDR_W > BYTE_W) begin : g_bad_addr
         $error("i2c_eeprom_target: one address byte covers at most 8 bits");
      end
   endgenerate

   // line conditioning
   logic scl_s, scl_rise, scl_fall;
   logic sda_s, sda_rise, sda_fall;

   i2c_ee_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .din(scl_i),
      .level(scl_s), .rise(scl_rise), .fall(scl_fall)
   );

   i2c_ee_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .din(sda_i),
      .level(sda_s), .rise(sda_rise), .fall(sda_fall)
   );

   logic start_det, stop_det;
   assign start_det = sda_fall & scl_s;
   assign stop_det  = sda_rise & scl_s;

   // state
   bus_state_e           state_q;
   logic [BITCNT_W-1:0]  bit_cnt_q;
   logic [BYTE_W-1:0]    shift_q;
   logic [ADDR_W-1:0]    ptr_q;
   logic                 rd_sel_q;
   logic                 wr_pend_q;
   logic                 host_ack_q;

   logic                 wr_busy;
   logic                 cycle_go;
   logic                 arr_we;
   logic [BYTE_W-1:0]    arr_rdata;

   assign cycle_go = stop_det & wr_pend_q;
   assign arr_we   = (state_q == ST_WDATA) && scl_fall && (bit_cnt_q == LAST_BIT)
                     && !start_det && !stop_det && !wp_i;

   i2c_ee_wr_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(cycle_go), .busy(wr_busy)
   );

   i2c_ee_array #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_array (
      .clk(clk), .we(arr_we), .waddr(ptr_q), .wdata(shift_q),
      .raddr(ptr_q), .rdata(arr_rdata)
   );

   logic shifting_in;
   assign shifting_in = (state_q == ST_CTRL) || (state_q == ST_ADDR) || (state_q == ST_WDATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         bit_cnt_q  <= '0;
         shift_q    <= '0;
         ptr_q      <= '0;
         rd_sel_q   <= 1'b0;
         wr_pend_q  <= 1'b0;
         host_ack_q <= 1'b0;
         sda_oe     <= 1'b0;
      end else if (stop_det) begin
         state_q   <= ST_IDLE;
         sda_oe    <= 1'b0;
         wr_pend_q <= 1'b0;
      end else if (start_det) begin
         state_q   <= ST_CTRL;
         bit_cnt_q <= '0;
         sda_oe    <= 1'b0;
      end else if (shifting_in) begin
         if (scl_rise && bit_cnt_q != LAST_BIT) begin
            shift_q   <= {shift_q[BYTE_W-2:0], sda_s};
            bit_cnt_q <= bit_cnt_q + 1'b1;
         end else if (scl_fall && bit_cnt_q == LAST_BIT) begin
            unique case (state_q)
               ST_CTRL: begin
                  if (shift_q[7:1] == DEV_ADDR && !wr_busy) begin
                     rd_sel_q <= shift_q[0];
                     sda_oe   <= 1'b1;
                     state_q  <= ST_CTRL_ACK;
                  end else begin
                     state_q  <= ST_IDLE;
                  end
               end
               ST_ADDR: begin
                  ptr_q   <= shift_q[ADDR_W-1:0];
                  sda_oe  <= 1'b1;
                  state_q <= ST_ADDR_ACK;
               end
               default: begin
                  if (!wp_i) wr_pend_q <= 1'b1;
                  ptr_q   <= ptr_q + PTR_ONE;
                  sda_oe  <= 1'b1;
                  state_q <= ST_WDATA_ACK;
               end
            endcase
         end
      end else begin
         unique case (state_q)
            ST_CTRL_ACK: begin
               if (scl_fall) begin
                  bit_cnt_q <= '0;
                  if (rd_sel_q) begin
                     shift_q <= arr_rdata;
                     ptr_q   <= ptr_q + PTR_ONE;
                     sda_oe  <= ~arr_rdata[7];
                     state_q <= ST_RDATA;
                  end else begin
                     sda_oe  <= 1'b0;
                     state_q <= ST_ADDR;
                  end
               end
            end
            ST_ADDR_ACK, ST_WDATA_ACK: begin
               if (scl_fall) begin
                  sda_oe    <= 1'b0;
                  bit_cnt_q <= '0;
                  state_q   <= ST_WDATA;
               end
            end
            ST_RDATA: begin
               if (scl_rise) begin
                  bit_cnt_q <= bit_cnt_q + 1'b1;
               end else if (scl_fall) begin
                  if (bit_cnt_q == LAST_BIT) begin
                     sda_oe  <= 1'b0;
                     state_q <= ST_RACK;
                  end else begin
                     sda_oe  <= ~shift_q[6];
                     shift_q <= {shift_q[BYTE_W-2:0], 1'b0};
                  end
               end
            end
            ST_RACK: begin
               if (scl_rise) begin
                  host_ack_q <= ~sda_s;
               end else if (scl_fall) begin
                  if (host_ack_q) begin
                     shift_q   <= arr_rdata;
                     ptr_q     <= ptr_q + PTR_ONE;
                     sda_oe    <= ~arr_rdata[7];
                     bit_cnt_q <= '0;
                     state_q   <= ST_RDATA;
                  end else begin
                     state_q   <= ST_IDLE;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   AST_NO_ACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_CTRL && scl_fall && bit_cnt_q == LAST_BIT && wr_busy
       && !start_det && !stop_det) |=> !sda_oe); // R2

   AST_CYCLE_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_go |=> wr_busy); // R1

   AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe); // R7

   AST_DRIVE_IN_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_s); // R10

   AST_PROTECT_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (wp_i && !wr_pend_q && !stop_det && !start_det) |=> !wr_pend_q || !$past(wp_i)); // R3
endmodule

// File: tb/i2c_eeprom_target_tb.sv
module i2c_eeprom_target_tb;
   localparam int unsigned WC = 400;
   localparam int Q = 10;
   localparam logic [7:0] CW = 8'hA0;
   localparam logic [7:0] CR = 8'hA1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic wp = 1'b0;
   logic sda_oe;
   wire  sda_line = sda_m & ~sda_oe;

   always #4 clk = ~clk;

   i2c_eeprom_target #(.ADDR_W(8), .DEV_ADDR(7'h50), .WRITE_CYCLES(WC), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_oe(sda_oe), .wp_i(wp)
   );

   int vectors = 0;
   int fails = 0;
   int cyc = 0;
   int viol = 0;
   bit done = 1'b0;

   int    exp_q[$];
   string tag_q[$];
   int    obs_q[$];

   always @(posedge clk) cyc <= cyc + 1;

   // SDA drive must not change across a high SCL phase (R10)
   logic scl_prev = 1'b1, oe_prev = 1'b0;
   always @(negedge clk) begin
      if (rst_n && scl_m && scl_prev && (sda_oe !== oe_prev)) viol++;
      scl_prev <= scl_m;
      oe_prev  <= sda_oe;
   end

   task automatic expect_v(string t, int v);
      tag_q.push_back(t);
      exp_q.push_back(v);
   endtask

   task automatic observe(int v);
      obs_q.push_back(v);
   endtask

   // scoreboard monitor
   initial begin
      forever begin
         @(negedge clk);
         while (obs_q.size() > 0 && exp_q.size() > 0) begin
            int a, e;
            string t;
            a = obs_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            vectors++;
            if (a != e) begin
               fails++;
               $display("FAIL %s: actual %0h expected %0h", t, a, e);
            end
         end
      end
   end

   task automatic hold(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start;
      sda_m = 1'b1; hold(Q);
      scl_m = 1'b1; hold(Q);
      sda_m = 1'b0; hold(Q);
      scl_m = 1'b0; hold(Q);
   endtask

   task automatic bus_stop;
      sda_m = 1'b0; hold(Q);
      scl_m = 1'b1; hold(Q);
      sda_m = 1'b1; hold(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; hold(Q);
         scl_m = 1'b1; hold(Q);
         scl_m = 1'b0; hold(2);
      end
      sda_m = 1'b1; hold(Q);
      scl_m = 1'b1; hold(Q);
      ack = !sda_line;
      scl_m = 1'b0; hold(2);
   endtask

   task automatic recv_byte(input bit mack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         hold(Q);
         scl_m = 1'b1; hold(Q);
         b[i] = sda_line;
         scl_m = 1'b0; hold(2);
      end
      sda_m = !mack; hold(Q);
      scl_m = 1'b1; hold(Q);
      scl_m = 1'b0; hold(2);
      sda_m = 1'b1;
   endtask

   task automatic poll_once(output bit ack);
      bus_start;
      send_byte(CW, ack);
      bus_stop;
   endtask

   task automatic wait_ready;
      bit ack;
      ack = 1'b0;
      for (int k = 0; k < 40 && !ack; k++) poll_once(ack);
   endtask

   task automatic write_bytes(input logic [7:0] a, input logic [7:0] d [4], input int n);
      bit ack;
      bus_start;
      send_byte(CW, ack);
      send_byte(a, ack);
      for (int k = 0; k < n; k++) send_byte(d[k], ack);
      bus_stop;
   endtask

   task automatic rand_read(input logic [7:0] a, output logic [7:0] b);
      bit ack;
      bus_start;
      send_byte(CW, ack);
      send_byte(a, ack);
      bus_start;
      send_byte(CR, ack);
      recv_byte(1'b0, b);
      bus_stop;
   endtask

   initial begin
      bit ack;
      logic [7:0] got;
      int t0, elapsed, nak_polls;
      hold(10);
      rst_n = 1'b1;
      hold(10);

      expect_v("R10 SDA released after reset", 0);
      observe(sda_oe);

      // foreign address
      expect_v("R4 foreign address not acknowledged", 0);
      bus_start; send_byte(8'hA4, ack); observe(ack); bus_stop;

      // write two bytes at 0x10
      expect_v("R2 control byte acknowledged when idle", 1);
      expect_v("R1 data byte acknowledged", 1);
      bus_start; send_byte(CW, ack); observe(ack);
      send_byte(8'h10, ack);
      send_byte(8'hA5, ack);
      send_byte(8'h3C, ack); observe(ack);
      bus_stop;
      t0 = cyc;

      // back-to-back acknowledge polling
      expect_v("R2 first poll refused while busy", 0);
      poll_once(ack); observe(ack);
      nak_polls = 1;
      while (!ack && nak_polls < 40) begin
         poll_once(ack);
         if (!ack) nak_polls++;
      end
      elapsed = cyc - t0;
      expect_v("R2 poll acknowledged after cycle", 1);
      observe(ack);
      expect_v("R1 busy interval matches WRITE_CYCLES", 1);
      observe(int'(elapsed >= int'(WC) - 2*Q && elapsed <= int'(WC) + 700));

      // random read then current-address read
      expect_v("R8 random read from loaded address", 8'hA5);
      rand_read(8'h10, got); observe(got);
      expect_v("R7 SDA released after NAK and stop", 0);
      observe(sda_oe);
      expect_v("R1 no busy after address-only write", 1);
      poll_once(ack); observe(ack);
      expect_v("R6 read control byte acknowledged", 1);
      expect_v("R5 current-address read returns n+1", 8'h3C);
      bus_start; send_byte(CR, ack); observe(ack);
      recv_byte(1'b0, got); observe(got);
      bus_stop;

      // sequential write and read across the top of the array
      write_bytes(8'hFE, '{8'h11, 8'h22, 8'h33, 8'h00}, 3);
      wait_ready;
      expect_v("R9 sequential byte at 0xFE", 8'h11);
      expect_v("R9 sequential byte at 0xFF", 8'h22);
      expect_v("R9 sequential byte wraps to 0x00", 8'h33);
      bus_start; send_byte(CW, ack); send_byte(8'hFE, ack);
      bus_start; send_byte(CR, ack);
      recv_byte(1'b1, got); observe(got);
      recv_byte(1'b1, got); observe(got);
      recv_byte(1'b0, got); observe(got);
      bus_stop;

      // write protect
      wp = 1'b1;
      expect_v("R3 data acknowledged under protect", 1);
      bus_start; send_byte(CW, ack); send_byte(8'h10, ack);
      send_byte(8'h77, ack); observe(ack);
      bus_stop;
      expect_v("R3 no write cycle under protect", 1);
      poll_once(ack); observe(ack);
      expect_v("R3 array unchanged under protect", 8'hA5);
      rand_read(8'h10, got); observe(got);
      wp = 1'b0;

      // read control byte refused while busy, then write visible
      write_bytes(8'h20, '{8'h5A, 8'h00, 8'h00, 8'h00}, 1);
      expect_v("R2 read control byte refused while busy", 0);
      bus_start; send_byte(CR, ack); observe(ack); bus_stop;
      wait_ready;
      expect_v("R4 write selected by R/W bit 0", 8'h5A);
      rand_read(8'h20, got); observe(got);

      expect_v("R10 SDA drive stable while SCL high", 0);
      observe(viol);

      hold(5);
      if (exp_q.size() != 0 || obs_q.size() != 0) begin
         fails++;
         $display("FAIL scoreboard: actual %0d expected %0d leftover items", exp_q.size() + obs_q.size(), 0);
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d cycles", 200000, 0);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end
endmodule